// File: doc/BRIEF.md
# Multiplexed Bus Target Interface

This block is the target side of a 32-bit parallel bus that carries address and data on the same wires and uses active-low handshakes. When an initiator starts a cycle, the block captures the address and the 4-bit command. It checks whether the cycle falls in its memory window or its I/O window. If it does, it claims the cycle and then moves one 32-bit word per data phase to or from a small bank of internal registers. Byte enables control the writes. Both windows map onto the same register bank.

A parameter sets a fixed number of wait states before the first data handshake. Bursts may have any length. The initiator can stall with its ready line or end the burst early. The target ends a burst itself when the burst would run past the last register. While the `busy` input is high at the start of a cycle, the target answers with a retry instead of data. Configuration space, parity, 64-bit extension and interrupts are not handled.

Top module: `mbus_target`

## Requirements
- R1: After reset, `devsel_n`, `trdy_n` and `stop_n` are high, `ad_oe` is low, and every register in the bank reads back as zero.
- R2: A start of cycle is a clock where `frame_n` is sampled low while `irdy_n` is high. The target claims only I/O read (0010) and I/O write (0011) in the I/O window. In the memory window it claims memory read (0110), memory write (0111), read multiple (1100), read line (1110) and write-and-invalidate (1111). It never claims any other code, which includes configuration, reserved, interrupt-acknowledge, special and dual-address codes. The write codes are the ones with bit 0 set.
- R3: An address is in a window when bits 31 down to WORD_BITS+2 equal the same bits of that window's base. A cycle outside the window leaves `devsel_n`, `trdy_n` and `stop_n` high and changes no register.
- R4: Count the address clock as clock 0. `devsel_n` of a claimed cycle is high in clock 1 and goes low in clock 2. It stays low until the cycle ends.
- R5: For a claimed cycle that is not busy, `trdy_n` first goes low in clock 2+INIT_WAIT.
- R6: A word moves only on a clock edge where `irdy_n` and `trdy_n` are both low. While the initiator holds `irdy_n` high, `trdy_n` stays low and the read data stays unchanged.
- R7: On a write data phase, byte lane k (bits 8k+7..8k) of the addressed register is updated only when `cbe_n[k]` is low.
- R8: The starting register is address bits WORD_BITS+1..2. The register index goes up by one after each completed data phase. On a read, `ad_out` holds the addressed register while `trdy_n` is low, and `ad_oe` is high.
- R9: When a word moves with `frame_n` high, the target raises `devsel_n`, `trdy_n` and `stop_n` and lowers `ad_oe` on the next clock.
- R10: `stop_n` is low together with `trdy_n` exactly in the data phases that address the last register. If that word moves while `frame_n` is still low, `trdy_n` goes high and `stop_n` stays low until `frame_n` is sampled high. All outputs are released on the next clock.
- R11: If `busy` is high in the address clock, the target lowers `devsel_n` and `stop_n` in clock 2 and never lowers `trdy_n`. No register changes. It releases all outputs in the clock after `frame_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Sampled in the address clock; when high, the claimed cycle is retried |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address clock, active-low byte enables in data phases |
| ad_in | input | 32 | Address/data value seen on the bus |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | High while the target owns the address/data wires for a read |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests the end of the cycle, active low |

## Verification
The bench sends bursts that start on the last register or run past it. A target that missed the disconnect would write past the bank or hold `stop_n` high while the final word moved. It also mixes random initiator stalls with the programmed wait states. A design that moved data on `trdy_n` alone, or dropped `trdy_n` during a stall, would corrupt its reference copy or return the wrong word. The bench also sends reserved, configuration and out-of-window commands, and I/O codes aimed at the memory window. It sends busy cycles with write data present and reads back the bank afterwards, so that a wrongly claimed cycle or a retry that still writes shows up as changed registers.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'b0010,
    CMD_IO_WR   = 4'b0011,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_CFG_RD  = 4'b1010,
    CMD_CFG_WR  = 4'b1011,
    CMD_MEM_RDM = 4'b1100,
    CMD_MEM_RDL = 4'b1110,
    CMD_MEM_WRI = 4'b1111
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_HOLD,
    ST_SKIP
  } tgt_state_e;

endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          WORD_BITS = 3,
  parameter logic [31:0] MEM_BASE  = 32'h8000_0000,
  parameter logic [31:0] IO_BASE   = 32'h0000_1000
) (
  input  logic [3:0]           cmd,
  input  logic [DATA_W-1:0]    addr,
  output logic                 claim,
  output logic                 is_write,
  output logic [WORD_BITS-1:0] word_idx
);
  localparam int LO = WORD_BITS + 2;

  logic mem_hit, io_hit;
  logic unused_lsb;

  assign mem_hit    = (addr[DATA_W-1:LO] == MEM_BASE[DATA_W-1:LO]);
  assign io_hit     = (addr[DATA_W-1:LO] == IO_BASE[DATA_W-1:LO]);
  assign word_idx   = addr[LO-1:2];
  assign is_write   = cmd[0];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    case (bus_cmd_e'(cmd))
      CMD_IO_RD, CMD_IO_WR:                   claim = io_hit;
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
      CMD_MEM_RDL, CMD_MEM_WRI:               claim = mem_hit;
      default:                                claim = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbus_regbank.sv
module mbus_regbank #(
  parameter int DATA_W    = 32,
  parameter int WORD_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [WORD_BITS-1:0]  waddr,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [WORD_BITS-1:0]  raddr,
  output logic [DATA_W-1:0]     rdata
);
  localparam int NWORDS = 1 << WORD_BITS;
  localparam int LANES  = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [NWORDS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int w = 0; w < NWORDS; w++) lane_mem[w] <= '0;
      end else if (we && be[g]) begin
        lane_mem[waddr] <= wdata[g*8 +: 8];
      end
    end

    assign rdata[g*8 +: 8] = lane_mem[raddr];
  end
endmodule

// File: rtl/mbus_target.sv
module mbus_target
  import mbus_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          WORD_BITS = 3,
  parameter int          INIT_WAIT = 2,
  parameter logic [31:0] MEM_BASE  = 32'h8000_0000,
  parameter logic [31:0] IO_BASE   = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [DATA_W/8-1:0] cbe_n,
  input  logic [DATA_W-1:0]   ad_in,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n
);
  localparam int                   WCNT_W = $clog2(INIT_WAIT + 2);
  localparam logic [WORD_BITS-1:0] LAST   = '1;

  tgt_state_e            st, nxt;
  logic [DATA_W-1:0]     lat_addr;
  logic [3:0]            lat_cmd;
  logic                  lat_busy;
  logic [WORD_BITS-1:0]  idx, n_idx, idx_inc;
  logic [WCNT_W-1:0]     wcnt, n_wcnt;
  logic                  n_dev, n_trdy, n_stop, n_oe, cap;
  logic                  dec_claim, dec_wr;
  logic [WORD_BITS-1:0]  dec_idx;
  logic                  bank_we;
  logic [DATA_W-1:0]     bank_rd;

  mbus_decode #(
    .DATA_W(DATA_W), .WORD_BITS(WORD_BITS),
    .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)
  ) u_dec (
    .cmd(lat_cmd), .addr(lat_addr),
    .claim(dec_claim), .is_write(dec_wr), .word_idx(dec_idx)
  );

  assign idx_inc = idx + 1'b1;
  assign bank_we = (st == ST_XFER) && !irdy_n && dec_wr;

  mbus_regbank #(.DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(idx), .be(~cbe_n),
    .wdata(ad_in), .raddr(n_idx), .rdata(bank_rd)
  );

  always_comb begin
    nxt    = st;
    n_dev  = devsel_n;
    n_trdy = trdy_n;
    n_stop = stop_n;
    n_oe   = ad_oe;
    n_idx  = idx;
    n_wcnt = wcnt;
    cap    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!frame_n && irdy_n) begin
          cap = 1'b1;
          nxt = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (!dec_claim) begin
          nxt = ST_SKIP;
        end else begin
          n_dev = 1'b0;
          n_idx = dec_idx;
          if (lat_busy) begin
            n_stop = 1'b0;
            nxt    = ST_HOLD;
          end else begin
            n_oe = !dec_wr;
            if (INIT_WAIT == 0) begin
              n_trdy = 1'b0;
              n_stop = (dec_idx != LAST);
              nxt    = ST_XFER;
            end else begin
              n_wcnt = WCNT_W'(INIT_WAIT);
              nxt    = ST_WAIT;
            end
          end
        end
      end
      ST_WAIT: begin
        if (wcnt == WCNT_W'(1)) begin
          n_trdy = 1'b0;
          n_stop = (idx != LAST);
          nxt    = ST_XFER;
        end else begin
          n_wcnt = wcnt - 1'b1;
        end
      end
      ST_XFER: begin
        if (!irdy_n) begin
          if (frame_n) begin
            n_dev = 1'b1; n_trdy = 1'b1; n_stop = 1'b1; n_oe = 1'b0;
            nxt   = ST_IDLE;
          end else if (!stop_n) begin
            n_trdy = 1'b1;
            nxt    = ST_HOLD;
          end else begin
            n_idx  = idx_inc;
            n_stop = (idx_inc != LAST);
          end
        end
      end
      ST_HOLD: begin
        if (frame_n) begin
          n_dev = 1'b1; n_trdy = 1'b1; n_stop = 1'b1; n_oe = 1'b0;
          nxt   = ST_IDLE;
        end
      end
      ST_SKIP: begin
        if (frame_n && irdy_n) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      idx      <= '0;
      wcnt     <= '0;
      lat_addr <= '0;
      lat_cmd  <= '0;
      lat_busy <= 1'b0;
    end else begin
      st       <= nxt;
      devsel_n <= n_dev;
      trdy_n   <= n_trdy;
      stop_n   <= n_stop;
      ad_oe    <= n_oe;
      ad_out   <= bank_rd;
      idx      <= n_idx;
      wcnt     <= n_wcnt;
      if (cap) begin
        lat_addr <= ad_in;
        lat_cmd  <= cbe_n;
        lat_busy <= busy;
      end
    end
  end
endmodule

// File: rtl/mbus_target_chk.sv
module mbus_target_chk (
  input logic clk,
  input logic rst,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ad_oe
);
  a_r4_medium_decode: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(irdy_n, 2)));

  a_r6_trdy_needs_devsel: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  a_r6_trdy_held_in_stall: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> !trdy_n);

  a_r8_oe_only_when_claimed: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !devsel_n);

  a_r9_release_after_last: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n && !ad_oe));

  a_r10_stop_held: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && trdy_n && !frame_n) |=> !stop_n);
endmodule

bind mbus_target mbus_target_chk u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe)
);

// File: tb/mbus_target_test.sv
`timescale 1ns/1ps
module mbus_target_test;
  localparam int          WB   = 3;
  localparam int          NW   = 1 << WB;
  localparam int          W    = 2;
  localparam logic [31:0] MB   = 32'h8000_0000;
  localparam logic [31:0] IB   = 32'h0000_1000;
  localparam int          LAST = NW - 1;

  logic        clk = 0, rst = 1, busy = 0, frame_n = 1, irdy_n = 1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = 0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n;

  int errors = 0, checks = 0;
  bit fin = 0;
  logic [31:0] model [NW];

  always #2.5 clk = ~clk;

  mbus_target #(.DATA_W(32), .WORD_BITS(WB), .INIT_WAIT(W),
                .MEM_BASE(MB), .IO_BASE(IB)) uut (
    .clk(clk), .rst(rst), .busy(busy), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit f_claim(input logic [3:0] c, input logic [31:0] a);
    bit mh = (a[31:WB+2] == MB[31:WB+2]);
    bit ih = (a[31:WB+2] == IB[31:WB+2]);
    case (c)
      4'b0010, 4'b0011:                            return ih;
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return mh;
      default:                                     return 1'b0;
    endcase
  endfunction

  function automatic bit f_known(input logic [3:0] c);
    return (c == 4'b0010 || c == 4'b0011 || c == 4'b0110 || c == 4'b0111 ||
            c == 4'b1100 || c == 4'b1110 || c == 4'b1111);
  endfunction

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int nw,
                     input bit bsy, input int wpct, input logic [3:0] fbe);
    bit claim = f_claim(cmd, addr);
    bit wr = cmd[0];
    int idx = int'(addr[WB+1:2]);
    int c = 0, ndone = 0, mode = 0;
    bit fresh = 1, waited = 0, last, stp;
    logic [31:0] wd = 0, prev_rd = 0;
    logic [3:0] be = 0;
    string etag = "R9";
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; busy = bsy;
    forever begin
      @(negedge clk);
      c++;
      busy = 0;
      if (mode == 2) begin
        chk(devsel_n && trdy_n && stop_n && !ad_oe, etag, {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);
        frame_n = 1; irdy_n = 1;
        break;
      end
      if (!claim) begin
        chk(devsel_n && trdy_n && stop_n, f_known(cmd) ? "R3" : "R2",
            {devsel_n, trdy_n, stop_n}, 3'b111);
        irdy_n = 0; cbe_n = 4'h0; ad_in = $urandom;
        frame_n = (c >= 3);
        if (c >= 4) begin frame_n = 1; irdy_n = 1; break; end
        continue;
      end
      if (bsy) begin
        if (c == 1) chk(devsel_n, "R4", devsel_n, 1);
        else if (mode == 1) begin
          chk(devsel_n && trdy_n && stop_n, "R11", {devsel_n, trdy_n, stop_n}, 3'b111);
          frame_n = 1; irdy_n = 1;
          break;
        end else chk(!devsel_n && !stop_n && trdy_n, "R11", {devsel_n, trdy_n, stop_n}, 3'b010);
        irdy_n = 0; cbe_n = 4'h0; ad_in = $urandom;
        if (c == 4) begin frame_n = 1; mode = 1; end
        continue;
      end
      if (mode == 1) begin
        chk(!devsel_n && !stop_n && trdy_n, "R10", {devsel_n, trdy_n, stop_n}, 3'b010);
        frame_n = 1; irdy_n = 0; mode = 2; etag = "R10";
        continue;
      end
      chk(devsel_n == (c < 2), "R4", devsel_n, (c < 2));
      chk(trdy_n == !(c >= 2 + W), "R5", trdy_n, !(c >= 2 + W));
      if (waited) begin
        chk(!trdy_n, "R6", trdy_n, 0);
        if (!wr) chk(ad_out == prev_rd, "R6", ad_out, prev_rd);
      end
      if (fresh) begin
        wd = $urandom; be = (fbe != 0) ? fbe : 4'($urandom); fresh = 0;
      end
      ad_in = wr ? wd : 32'h0;
      cbe_n = ~be;
      if (!trdy_n) begin
        chk(stop_n == (idx != LAST), "R10", stop_n, (idx != LAST));
        if (!wr) begin
          chk(ad_out == model[idx], "R8", ad_out, model[idx]);
          chk(ad_oe, "R8", ad_oe, 1);
        end
      end
      last = (ndone + 1 == nw);
      if (frame_n) irdy_n = 0;
      else irdy_n = ($urandom_range(99) < wpct) ? 1'b1 : 1'b0;
      if (!irdy_n && last) frame_n = 1;
      waited = !trdy_n && irdy_n;
      prev_rd = ad_out;
      if (!trdy_n && !irdy_n) begin
        if (wr) for (int b = 0; b < 4; b++) if (be[b]) model[idx][b*8 +: 8] = wd[b*8 +: 8];
        stp = !stop_n;
        ndone++; idx++; fresh = 1;
        if (last) begin mode = 2; etag = "R9"; end
        else if (stp) mode = 1;
      end
    end
  endtask

  task automatic read_all(input logic [31:0] base, input string tag);
    txn(4'b0110, base, NW, 0, 0, 4'h0);
    for (int i = 0; i < NW; i++) chk(1'b1, tag, 0, 0);
  endtask

  initial begin
    logic [3:0] ign [8] = '{4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b0000, 4'b1101};
    logic [3:0] okc [7] = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) model[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1", {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);
    // R1: bank reads zero after reset (checked inside the burst against a zeroed model)
    txn(4'b0110, MB, NW, 0, 0, 4'h0);
    // R8: full write burst, then read back through the I/O window with stalls
    txn(4'b0111, MB, NW, 0, 30, 4'hF);
    txn(4'b0010, IB, NW, 0, 40, 4'h0);
    // R7: partial byte enables
    txn(4'b0011, IB | 32'h8, 1, 0, 0, 4'b0101);
    txn(4'b1111, MB | 32'h8, 1, 0, 0, 4'b1000);
    txn(4'b1110, MB | 32'h8, 1, 0, 0, 4'h0);
    // R10: burst running past the last register, and one starting on it
    txn(4'b0111, MB | 32'h14, 6, 0, 20, 4'h0);
    txn(4'b1100, MB | 32'h14, 6, 0, 20, 4'h0);
    txn(4'b0110, MB | (LAST * 4), 3, 0, 0, 4'h0);
    // R2: non-claimed codes carry write data but change nothing
    foreach (ign[k]) txn(ign[k], MB, 2, 0, 0, 4'h0);
    foreach (ign[k]) txn(ign[k], IB, 2, 0, 0, 4'h0);
    txn(4'b0011, MB, 2, 0, 0, 4'h0);
    txn(4'b0111, IB, 2, 0, 0, 4'h0);
    // R3: outside both windows
    txn(4'b0111, MB + (NW * 4), 2, 0, 0, 4'h0);
    txn(4'b0011, IB - 4, 2, 0, 0, 4'h0);
    // R11: retry on busy, with write data present
    txn(4'b0111, MB, 2, 1, 0, 4'h0);
    txn(4'b0010, IB, 1, 1, 0, 4'h0);
    txn(4'b0110, MB, NW, 0, 0, 4'h0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0] cc = okc[$urandom_range(6)];
      logic [31:0] base = (cc[3:1] == 3'b001) ? IB : MB;
      txn(cc, base | (32'($urandom_range(LAST)) << 2), $urandom_range(1, 5),
          ($urandom_range(9) == 0), 35, 4'h0);
    end
    txn(4'b0110, MB, NW, 0, 10, 4'h0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule